// File: doc/BRIEF.md
# Frequency-Locked Loop Lock Detector

This block decides whether a frequency-locked loop has settled. It samples the up and down correction pulses of the loop on the rising edge of the monitor clock. When an end-of-conversion indication arrives, it opens a short counting window whose length is chosen by a 2-bit code. If one correction direction shows enough rising edges inside that window, the block declares lock.

While it holds lock, the block watches for corrections that keep running in one direction. A sustained run of the increment or decrement level means the loop has drifted away, so the lock flag is dropped. The block then waits for a fresh end-of-conversion before it tries again. Pulling the enable low abandons any attempt and clears lock.

Top module: `fld_lock_detect`

## Requirements
- R1: While `rst_n` or `en` is low, `lock` reads 0 one clock later, and any attempt in progress is abandoned.
- R2: A lock attempt arms only from the idle state, on a clock where `en` is high and `eoc` is 1. Counting begins on the next clock. A rising edge that falls in the arming clock itself is not counted. A rising edge means the input is high on this clock and was low on the clock before.
- R3: During the window, `lock` goes to 1 one clock after the clock that carries the second rising edge of `inc`. The two edges need not be adjacent.
- R4: Rising edges of `dec` are counted the same way, in a separate tally. One `inc` edge plus one `dec` edge never yields lock, because the two tallies are never added together.
- R5: The code on `win_code`, captured at arming, sets the window to 6 + 2*code clocks: 00→6, 01→8, 10→10, 11→12. An edge on the last clock of the window still counts. Reaching the threshold on that clock wins over expiry.
- R6: A window that ends without reaching the threshold returns the block to idle with both tallies cleared. Later edges have no effect until `eoc` is seen again.
- R7: Once locked, `lock` drops one clock after `inc` has been high on 4 consecutive clocks, or `dec` has been high on 4 consecutive clocks. Levels are used, not edges, and there is no time limit. A low clock restarts that direction's run. `eoc` is ignored while locked.
- R8: A clock with both `inc` and `dec` high advances both runs.
- R9: After lock drops, edges alone do not relock. A new `eoc` is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampled monitor clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Detector enable; low clears the state |
| eoc | input | 1 | End-of-conversion indication that arms an attempt |
| inc | input | 1 | Increment correction from the loop |
| dec | input | 1 | Decrement correction from the loop |
| win_code | input | 2 | Window length code |
| lock | output | 1 | Lock flag |

## Verification
Two events can fall on the same clock: the threshold edge and the expiry of the window. The bench places the second edge on the very last clock of windows with different codes, and it also places it one clock too late. The first must lock and the second must return to idle. Simultaneous `inc` and `dec` activity is also driven. One edge of each direction inside a window must not lock, and both levels held high while locked must unlock after four clocks. Every outcome is judged against a behavioural model that is compared on each clock.

// File: rtl/fld_pkg.sv
package fld_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARMED  = 2'd1,
      ST_LOCKED = 2'd2
   } fld_state_e;

   localparam int N_DIR = 2;  // index 0 = increment, 1 = decrement
endpackage

// File: rtl/fld_count.sv
// Saturating event counter; CONSEC selects a consecutive-run variant
// that restarts on any clock without the event.
module fld_count #(
   parameter int THR    = 2,
   parameter bit CONSEC = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic pulse,
   output logic hit
);
   localparam int CW = $clog2(THR + 1);

   if (THR < 1) begin : g_bad_thr
      $error("fld_count: THR must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;

   assign cnt_inc = (cnt == CW'(THR)) ? cnt : cnt + 1'b1;
   assign hit     = !clr && pulse && (cnt >= CW'(THR - 1));

   if (CONSEC) begin : g_run
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt <= '0;
         else if (clr)   cnt <= '0;
         else if (pulse) cnt <= cnt_inc;
         else            cnt <= '0;
      end
   end else begin : g_tally
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt <= '0;
         else if (clr)   cnt <= '0;
         else if (pulse) cnt <= cnt_inc;
      end
   end
endmodule

// File: rtl/fld_window.sv
// Programmable window timer: length captured at start, last flags final clock.
module fld_window #(
   parameter int CODE_W   = 2,
   parameter int BASE_WIN = 6,
   parameter int WIN_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              last
);
   localparam int MAX_LEN = BASE_WIN + WIN_STEP * ((1 << CODE_W) - 1);
   localparam int CW      = $clog2(MAX_LEN + 1);

   if (BASE_WIN < 1 || WIN_STEP < 0) begin : g_bad_win
      $error("fld_window: window must be at least one clock");
   end

   logic [CW-1:0] len;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len <= CW'(BASE_WIN);
         cnt <= '0;
      end else if (start) begin
         len <= CW'(BASE_WIN + WIN_STEP * int'(code));
         cnt <= '0;
      end else if (run) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign last = run && (cnt == len - 1'b1);
endmodule

// File: rtl/fld_lock_detect.sv
module fld_lock_detect #(
   parameter int CODE_W   = 2,
   parameter int BASE_WIN = 6,
   parameter int WIN_STEP = 2,
   parameter int EDGE_THR = 2,
   parameter int RUN_THR  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              eoc,
   input  logic              inc,
   input  logic              dec,
   input  logic [CODE_W-1:0] win_code,
   output logic              lock
);
   import fld_pkg::*;

   fld_state_e       st, st_nx;
   logic [N_DIR-1:0] lvl, lvl_q, rise;
   logic [N_DIR-1:0] edge_hit, run_hit;
   logic             armed, locked, start, win_last;

   assign lvl    = {dec, inc};
   assign rise   = lvl & ~lvl_q;
   assign armed  = (st == ST_ARMED);
   assign locked = (st == ST_LOCKED);
   assign start  = en && (st == ST_IDLE) && eoc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      fld_count #(.THR(EDGE_THR), .CONSEC(1'b0)) u_edges (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (!(en && armed)),
         .pulse (rise[d]),
         .hit   (edge_hit[d])
      );
      fld_count #(.THR(RUN_THR), .CONSEC(1'b1)) u_run (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (!(en && locked)),
         .pulse (lvl[d]),
         .hit   (run_hit[d])
      );
   end

   fld_window #(
      .CODE_W   (CODE_W),
      .BASE_WIN (BASE_WIN),
      .WIN_STEP (WIN_STEP)
   ) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .run   (armed),
      .code  (win_code),
      .last  (win_last)
   );

   always_comb begin
      st_nx = st;
      if (!en) begin
         st_nx = ST_IDLE;
      end else begin
         unique case (st)
            ST_IDLE:   if (eoc) st_nx = ST_ARMED;
            ST_ARMED:  if (|edge_hit) st_nx = ST_LOCKED;
                       else if (win_last) st_nx = ST_IDLE;
            ST_LOCKED: if (|run_hit) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   assign lock = locked;
endmodule

// File: rtl/fld_lock_chk.sv
module fld_lock_chk #(
   parameter int RUN_THR = 4
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic inc,
   input logic dec,
   input logic lock
);
   localparam int SW = $clog2(RUN_THR + 1);

   logic          inc_q, dec_q;
   logic [SW-1:0] inc_s, dec_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc_q <= 1'b0;
         dec_q <= 1'b0;
         inc_s <= '0;
         dec_s <= '0;
      end else begin
         inc_q <= inc;
         dec_q <= dec;
         inc_s <= !inc ? '0 : (inc_s == SW'(RUN_THR)) ? inc_s : inc_s + 1'b1;
         dec_s <= !dec ? '0 : (dec_s == SW'(RUN_THR)) ? dec_s : dec_s + 1'b1;
      end
   end

   // R1: disabled detector reports no lock on the next clock
   a_r1_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !lock);

   // R3: lock can only appear right after a rising edge of one direction
   a_r3_lock_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> ((inc_q && !$past(inc_q)) || (dec_q && !$past(dec_q))));

   // R7: an enabled drop of lock needs a full run of one level
   a_r7_drop_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lock) && $past(en)) |->
         (inc_s >= SW'(RUN_THR) || dec_s >= SW'(RUN_THR)));

   // R7: a quiet clock while locked keeps lock
   a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && en && !inc && !dec) |=> lock);
endmodule

bind fld_lock_detect fld_lock_chk #(.RUN_THR(RUN_THR)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (en),
   .inc   (inc),
   .dec   (dec),
   .lock  (lock)
);

// File: tb/fld_lock_detect_tb.sv
module fld_lock_detect_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, eoc = 1'b0, inc = 1'b0, dec = 1'b0;
   logic [1:0] win_code = 2'b00;
   logic       lock;

   int n_chk = 0, n_bad = 0, cyc_n = 0;
   string cur_req = "R1";

   // behavioural reference
   int  m_st = 0, m_win = 0, m_len = 6, m_ni = 0, m_nd = 0, m_ri = 0, m_rd = 0;
   bit  m_pi = 0, m_pd = 0;
   bit  exp_lock;

   always #10 clk = ~clk;

   fld_lock_detect u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .eoc(eoc), .inc(inc), .dec(dec),
      .win_code(win_code), .lock(lock)
   );

   always @(posedge clk) begin
      cyc_n++;
      if (!rst_n || !en) begin
         m_st = 0;
      end else begin
         case (m_st)
            0: if (eoc) begin
                  m_st = 1; m_win = 0; m_ni = 0; m_nd = 0;
                  m_len = 6 + 2 * int'(win_code);
               end
            1: begin
                  m_win++;
                  if (inc && !m_pi) m_ni++;
                  if (dec && !m_pd) m_nd++;
                  if (m_ni >= 2 || m_nd >= 2) begin
                     m_st = 2; m_ri = 0; m_rd = 0;
                  end else if (m_win >= m_len) m_st = 0;
               end
            default: begin
                  m_ri = inc ? m_ri + 1 : 0;
                  m_rd = dec ? m_rd + 1 : 0;
                  if (m_ri >= 4 || m_rd >= 4) m_st = 0;
               end
         endcase
      end
      m_pi = rst_n ? inc : 1'b0;
      m_pd = rst_n ? dec : 1'b0;
      exp_lock = (m_st == 2);
   end

   task automatic check();
      n_chk++;
      if (lock !== exp_lock) begin
         n_bad++;
         $display("FAIL %s: lock=%b expected %b at cycle %0d", cur_req, lock, exp_lock, cyc_n);
      end
   endtask

   // check the current output, then drive the next input set
   task automatic step(input bit e, input bit o, input bit i, input bit d);
      @(negedge clk);
      check();
      en = e; eoc = o; inc = i; dec = d;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1"; check();           // reset state
      rst_n = 1'b1;
      idle(2);

      // R3: two non-adjacent inc edges, code 00
      cur_req = "R3"; win_code = 2'b00;
      step(1, 1, 0, 0); step(1, 0, 1, 0); step(1, 0, 0, 0); step(1, 0, 1, 0);
      idle(3);
      // R7: eoc ignored while locked, short runs restart
      cur_req = "R7";
      step(1, 1, 0, 0); step(1, 0, 1, 0); step(1, 0, 1, 0); step(1, 0, 1, 0);
      step(1, 0, 0, 0); step(1, 0, 1, 0); step(1, 0, 1, 0); step(1, 0, 1, 0);
      step(1, 0, 1, 0); idle(2);
      // R9: edges without eoc after the drop do not relock
      cur_req = "R9";
      step(1, 0, 1, 0); step(1, 0, 0, 0); step(1, 0, 1, 0); step(1, 0, 0, 0);
      idle(2);

      // R4: one inc edge plus one dec edge never locks, then expiry
      cur_req = "R4";
      step(1, 1, 0, 0); step(1, 0, 1, 1); step(1, 0, 0, 0); idle(6);
      // R6: edges after expiry have no effect
      cur_req = "R6";
      step(1, 0, 0, 1); step(1, 0, 0, 0); step(1, 0, 0, 1); idle(3);
      // R4: two dec edges lock
      cur_req = "R4";
      step(1, 1, 0, 0); step(1, 0, 0, 1); step(1, 0, 0, 0); step(1, 0, 0, 1);
      idle(2);
      // R8: both levels high advance both runs
      cur_req = "R8";
      step(1, 0, 1, 1); step(1, 0, 1, 1); step(1, 0, 1, 0); step(1, 0, 0, 1);
      step(1, 0, 1, 1); step(1, 0, 1, 1); step(1, 0, 1, 1); step(1, 0, 1, 1);
      idle(3);

      // R5: edge on the last clock of each window length
      cur_req = "R5";
      for (int c = 0; c < 4; c++) begin
         win_code = 2'(c);
         step(1, 1, 0, 0); step(1, 0, 1, 0); win_code = 2'(3 - c);
         for (int k = 2; k < 6 + 2 * c; k++) step(1, 0, 0, 0);
         step(1, 0, 1, 0); idle(2);
         step(1, 0, 1, 0); step(1, 0, 1, 0); step(1, 0, 1, 0); step(1, 0, 1, 0);
         idle(2);
      end
      // R5: edge one clock past the window (code 01) does not lock
      win_code = 2'b01;
      step(1, 1, 0, 0); step(1, 0, 1, 0);
      for (int k = 2; k < 9; k++) step(1, 0, 0, 0);
      step(1, 0, 1, 0); idle(3);

      // R2: rising edge in the arming clock is not counted
      cur_req = "R2"; win_code = 2'b00;
      step(1, 1, 1, 0); step(1, 0, 0, 0); step(1, 0, 1, 0); idle(6);

      // R1: enable low drops lock and aborts an attempt
      cur_req = "R1";
      step(1, 1, 0, 0); step(1, 0, 1, 0); step(1, 0, 0, 0); step(1, 0, 1, 0);
      idle(2); step(0, 1, 0, 0); step(1, 0, 0, 0);
      step(1, 1, 0, 0); step(1, 0, 1, 0); step(0, 0, 0, 0); step(1, 0, 1, 0);
      idle(3);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule